// File: doc/BRIEF.md
# Split Serial Buffer Reload Controller

This block manages a 256-word by 16-bit serial read buffer that is divided into a lower half (locations 0 to 127) and an upper half (locations 128 to 255). A host clocks words out of the buffer without ever stopping. While it does so, it can ask for the half it is not reading to be refilled from one quarter of a 512-column memory row. The memory row is fetched through a simple streaming port. The controller issues one request pulse with a row number and a column start. It then writes 128 strobed words, in arrival order, into the inactive half.

Each transfer request also carries an 8-bit tap. Tap bit 7 chooses between the two quarters of the row that may feed the target half. Bits 6 to 0 give the offset where reading resumes. That offset is parked in a holding register. The serial pointer keeps running until it reaches the last location of the half being read. On that clock the pointer jumps to the parked offset inside the freshly loaded half. If nothing is parked, the pointer simply runs on into the other half at offset 0.

Top module: `split_sam_ctrl`

## Requirements
- R1: After reset, ser_ptr is 0, ser_half is 0 (lower half active), ser_data is 0, xfer_busy is 0 and fetch_req is 0.
- R2: On each clock with ser_en high, ser_data takes the buffer word at the current ser_ptr and ser_ptr advances. With ser_en low, ser_ptr and ser_data hold. ser_half always equals ser_ptr bit 7.
- R3: An accepted transfer targets the half not being read. When the lower half is active, fetch_col is {1, tap[7], 7'b0}. When the upper half is active, it is {0, tap[7], 7'b0}.
- R4: fetch_req is a one-clock pulse on the clock after a request is accepted, with fetch_row equal to the requested row. The next 128 clocks with fetch_valid high write fetch_data to target-half base + 0, +1, ... +127 in order.
- R5: Accepting a request captures tap bits 6 to 0 without changing ser_ptr.
- R6: When ser_en is high, ser_ptr is at offset 127 of its half and a tap is pending, ser_ptr loads {target half, tap[6:0]} and the pending tap is cleared. The next enabled clock reads from that location.
- R7: When ser_ptr is at offset 127 with no tap pending, the next enabled clock moves it to offset 0 of the other half (127 to 128, 255 to 0).
- R8: xfer_busy is high while a tap is pending or a fill is incomplete. A request made while xfer_busy is high is refused: no fetch_req is issued and the earlier tap stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, free running |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Split transfer request |
| xfer_row | input | 9 | Row number for the transfer |
| xfer_tap | input | 8 | Bit 7 quarter select, bits 6:0 resume offset |
| ser_en | input | 1 | Serial read enable |
| ser_data | output | 16 | Registered serial output word |
| ser_ptr | output | 8 | Current serial pointer |
| ser_half | output | 1 | Active half (1 = upper) |
| xfer_busy | output | 1 | Tap pending or fill in progress |
| fetch_req | output | 1 | Row fetch request pulse |
| fetch_row | output | 9 | Row of the fetch |
| fetch_col | output | 9 | Column start of the fetch |
| fetch_valid | input | 1 | Fetched word strobe |
| fetch_data | input | 16 | Fetched word |

## Verification
The in-line properties check several rules on every cycle. They check that the pointer and output hold while reads are disabled and step by one away from a boundary. They check the jump to the parked offset at a boundary, and that the pointer stays put when a tap is captured with reads idle. They also check that no fetch pulse follows a refused request and that the fetch column points into the half that was inactive. The bench's reference model is needed to show that the right words land at the right addresses and come back out in order. It also shows that a refused request leaves the first tap in force and that reads keep flowing while a fill races the pointer.

// File: rtl/split_sam_ctrl.sv
module split_sam_ctrl #(
  parameter int DW      = 16,
  parameter int HALF_AW = 7,
  parameter int ROW_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic [ROW_W-1:0]   xfer_row,
  input  logic [HALF_AW:0]   xfer_tap,
  input  logic               ser_en,
  output logic [DW-1:0]      ser_data,
  output logic [HALF_AW:0]   ser_ptr,
  output logic               ser_half,
  output logic               xfer_busy,
  output logic               fetch_req,
  output logic [ROW_W-1:0]   fetch_row,
  output logic [HALF_AW+1:0] fetch_col,
  input  logic               fetch_valid,
  input  logic [DW-1:0]      fetch_data
);
  localparam int AW    = HALF_AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]      mem [DEPTH];
  logic [AW-1:0]      ptr;
  logic [HALF_AW-1:0] tap;
  logic [HALF_AW-1:0] fill_cnt;
  logic               pend, tgt_half, filling;

  wire at_stop = &ptr[HALF_AW-1:0];
  wire jump    = ser_en & pend & at_stop;
  wire accept  = xfer_req & ~xfer_busy;
  wire wr_en   = filling & fetch_valid;

  assign xfer_busy = pend | filling;
  assign ser_ptr   = ptr;
  assign ser_half  = ptr[AW-1];

  always_ff @(posedge clk)
    if (wr_en) mem[{tgt_half, fill_cnt}] <= fetch_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      pend      <= 1'b0;
      tap       <= '0;
      tgt_half  <= 1'b0;
      filling   <= 1'b0;
      fill_cnt  <= '0;
      ser_data  <= '0;
      fetch_req <= 1'b0;
      fetch_row <= '0;
      fetch_col <= '0;
    end else begin
      fetch_req <= accept;
      if (accept) begin
        pend      <= 1'b1;
        tap       <= xfer_tap[HALF_AW-1:0];
        tgt_half  <= ~ptr[AW-1];
        filling   <= 1'b1;
        fill_cnt  <= '0;
        fetch_row <= xfer_row;
        fetch_col <= {~ptr[AW-1], xfer_tap[AW-1], {HALF_AW{1'b0}}};
      end
      if (wr_en) begin
        fill_cnt <= fill_cnt + 1'b1;
        if (&fill_cnt) filling <= 1'b0;
      end
      if (ser_en) begin
        ser_data <= mem[ptr];
        if (jump) begin
          ptr  <= {tgt_half, tap};
          pend <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> $stable(ser_ptr) && $stable(ser_data));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en && !(pend && at_stop) |=> ser_ptr == AW'($past(ser_ptr) + 1'b1));

  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> ser_ptr == {$past(tgt_half), $past(tap)} && !pend);

  p_tap_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_busy && !ser_en |=> $stable(ser_ptr));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_busy |=> !fetch_req);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_col[AW] != $past(ser_ptr[AW-1]) && fetch_col[HALF_AW-1:0] == '0);
endmodule

// File: tb/split_sam_ctrl_tb_top.sv
`timescale 1ns/1ps
module split_sam_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, ser_en = 0, fetch_valid = 0;
  logic [8:0] xfer_row = 0;
  logic [7:0] xfer_tap = 0;
  logic [15:0] fetch_data = 0;
  logic [15:0] ser_data;
  logic [7:0] ser_ptr;
  logic ser_half, xfer_busy, fetch_req;
  logic [8:0] fetch_row, fetch_col;

  always #2.5 clk = ~clk;

  split_sam_ctrl dut_i (.*);

  int checks = 0, fails = 0;
  // reference model state
  int m_ptr, m_pend, m_tap, m_tgt, m_fill, m_cnt, m_freq, m_col, m_row;
  logic [15:0] m_buf [256];
  bit m_vld [256];
  logic [15:0] m_data;
  bit m_dv;
  string m_tag;
  // fetch responder
  int s_left = 0, s_row = 0, s_col = 0, s_idx = 0;
  bit gaps = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_pend = 0; m_tap = 0; m_tgt = 0; m_fill = 0; m_cnt = 0;
    m_freq = 0; m_col = 0; m_row = 0; m_data = 0; m_dv = 1; m_tag = "R2";
    for (int i = 0; i < 256; i++) m_vld[i] = 0;
  endtask

  task automatic model_step(bit req, int row, int tap, bit en, bit fv, logic [15:0] fd);
    int old_ptr = m_ptr;
    bit acc = req && !(m_pend || m_fill);
    m_tag = "R2";
    if (en) begin
      m_data = m_buf[m_ptr];
      m_dv = m_vld[m_ptr];
      if (m_ptr % 128 == 127 && m_pend) begin
        m_ptr = m_tgt * 128 + m_tap; m_pend = 0; m_tag = "R6";
      end else begin
        if (m_ptr % 128 == 127) m_tag = "R7";
        m_ptr = (m_ptr + 1) % 256;
      end
    end
    if (m_fill && fv) begin
      m_buf[m_tgt * 128 + m_cnt] = fd;
      m_vld[m_tgt * 128 + m_cnt] = 1;
      m_cnt++;
      if (m_cnt == 128) m_fill = 0;
    end
    m_freq = acc;
    if (acc) begin
      m_tgt = 1 - old_ptr / 128;
      m_pend = 1; m_fill = 1; m_cnt = 0;
      m_tap = tap % 128;
      m_row = row;
      m_col = m_tgt * 256 + (tap / 128) * 128;
      if (!en) m_tag = "R5";
    end
  endtask

  task automatic cyc(bit req, int row, int tap, bit en);
    bit fv;
    logic [15:0] fd;
    @(negedge clk);
    chk(ser_ptr == m_ptr[7:0], m_tag, ser_ptr, m_ptr);
    chk(ser_half == m_ptr[7], "R2", ser_half, m_ptr / 128);
    if (m_dv) chk(ser_data == m_data, "R4", ser_data, m_data);
    chk(xfer_busy == (m_pend || m_fill), "R8", xfer_busy, m_pend || m_fill);
    chk(fetch_req == m_freq[0], "R4", fetch_req, m_freq);
    if (fetch_req) begin
      chk(fetch_col == m_col[8:0], "R3", fetch_col, m_col);
      chk(fetch_row == m_row[8:0], "R4", fetch_row, m_row);
      s_left = 128; s_row = fetch_row; s_col = fetch_col; s_idx = 0;
    end
    fv = s_left > 0 && !(gaps && $urandom % 3 == 0);
    fd = 16'((s_row * 131 + s_col + s_idx) * 7);
    if (fv) begin s_left--; s_idx++; end
    xfer_req = req; xfer_row = 9'(row); xfer_tap = 8'(tap); ser_en = en;
    fetch_valid = fv; fetch_data = fd;
    model_step(req, row, tap, en, fv, fd);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    // R1 reset state
    chk(ser_ptr == 0, "R1", ser_ptr, 0);
    chk(ser_half == 0, "R1", ser_half, 0);
    chk(ser_data == 0, "R1", ser_data, 0);
    chk(xfer_busy == 0, "R1", xfer_busy, 0);
    chk(fetch_req == 0, "R1", fetch_req, 0);
    // R5: capture with reads idle; R3: lower active -> upper fill
    cyc(1, 3, 8'h85, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
    // R8: refused while pending
    cyc(1, 9, 8'h10, 0);
    for (int i = 0; i < 140; i++) cyc(0, 0, 0, 0);
    // R6: run to boundary, jump to 128+5
    for (int i = 0; i < 130; i++) cyc(0, 0, 0, 1);
    // upper active -> lower fill, jump to offset 2
    cyc(1, 7, 8'h02, 1);
    for (int i = 0; i < 260; i++) cyc(0, 0, 0, 1);
    // R7: free wrap with nothing pending
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1);
    // mixed traffic with fetch gaps and idle reads
    gaps = 1;
    for (int i = 0; i < 4000; i++)
      cyc($urandom % 40 == 0, $urandom % 512, $urandom % 256, $urandom % 4 != 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule